// File: doc/BRIEF.md
# Time-of-day alarm comparator with per-field wildcards

This block decides, once per timekeeping update, whether the current time of day matches a programmed alarm. It compares the current seconds, minutes and hours bytes with three alarm bytes written by the host. A match happens when every field either equals its alarm byte or has a wildcard alarm byte. On a match it sets a sticky alarm flag. An interrupt line follows that flag whenever alarm interrupts are enabled.

An alarm byte whose two most significant bits are both 1 (any value 0xC0 to 0xFF) is a wildcard and matches every value of its field. Leaving all three bytes specific gives one alarm per day. A wildcard hours byte gives one alarm per hour. Wildcard hours and minutes bytes give one per minute. Three wildcards give one per second. The comparison is a plain byte equality in whatever encoding the time counter uses, so in 12-hour mode the PM bit (bit 7 of the hours byte) takes part in it. The host clears the flag by reading the status register. That read is signalled to this block as a one-cycle strobe.

Top module: `alarm_match_unit`

## Requirements
- R1: After synchronous reset the alarm flag and the interrupt output are both 0.
- R2: On a clock edge where the update-done strobe is 1 and all three fields match, the alarm flag is 1 from the next cycle on.
- R3: Without the update-done strobe the flag never becomes set, however long the fields match.
- R4: An alarm byte with bits 7 and 6 both 1 (0xC0..0xFF) matches any current value of its field. An alarm byte with only one of those bits set is compared exactly.
- R5: If any field whose alarm byte is not a wildcard differs from its current value, an update does not set the flag.
- R6: Once set, the flag stays 1 until a status-read strobe. After a read with no new match on the same edge, the flag is 0 in the next cycle.
- R7: When a status read and a matching update fall on the same edge, the flag is 1 afterwards.
- R8: The flag is set by a match whatever the enable input is. The interrupt output equals flag AND enable.
- R9: A non-wildcard field matches only on equality of all 8 bits. For example, hours 0x85 (PM bit set) does not match an alarm byte of 0x05.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_done_i | input | 1 | One-cycle strobe after the time has advanced |
| alm_en_i | input | 1 | Alarm interrupt enable |
| flag_rd_i | input | 1 | One-cycle strobe from a host read of the status register, clears the flag |
| cur_sec_i | input | 8 | Current seconds byte |
| cur_min_i | input | 8 | Current minutes byte |
| cur_hr_i | input | 8 | Current hours byte (bit 7 is PM in 12-hour mode) |
| alm_sec_i | input | 8 | Seconds alarm byte |
| alm_min_i | input | 8 | Minutes alarm byte |
| alm_hr_i | input | 8 | Hours alarm byte |
| alm_flag_o | output | 1 | Sticky alarm flag |
| alm_irq_o | output | 1 | Alarm interrupt, flag gated by the enable |

## Verification
For each field in turn, every one of the 256 alarm byte values is paired with four current values: the equal value, a low-bit neighbour, and the values with bit 7 or bit 6 flipped. This separates the wildcard decode from a one-bit or PM-bit compare error and from a decode that tests only one of the two top bits. A second sweep runs all eight wildcard masks against eight time points. This separates the daily, hourly, per-minute and per-second behaviours. Directed sequences then exercise a held match without the strobe, a read that collides with a new match, a read with no match, and the enable gating, so the set and clear priority and the irq gate each show up on their own.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
    localparam int FW = 8;   // width of one time field byte
    localparam int NF = 3;   // seconds, minutes, hours

    typedef enum logic [1:0] {
        F_SEC = 2'd0,
        F_MIN = 2'd1,
        F_HR  = 2'd2
    } field_e;

    typedef logic [FW-1:0] fbyte_t;

    typedef struct packed {
        fbyte_t hr;
        fbyte_t min;
        fbyte_t sec;
    } tod_t;

    // both top bits set marks a don't-care alarm byte
    function automatic logic is_wild(input fbyte_t b);
        return &b[FW-1:FW-2];
    endfunction

    function automatic fbyte_t pick(input tod_t t, input int idx);
        case (idx)
            0:       return t.sec;
            1:       return t.min;
            default: return t.hr;
        endcase
    endfunction
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp
    import alarm_pkg::*;
(
    input  fbyte_t cur_i,
    input  fbyte_t alm_i,
    output logic   hit_o
);
    logic wild;
    logic same;

    always_comb begin
        wild  = is_wild(alm_i);
        same  = (cur_i == alm_i);
        hit_o = wild | same;
    end
endmodule

// File: rtl/alarm_flag_reg.sv
module alarm_flag_reg (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // a new match wins over a clear on the same edge
    always_ff @(posedge clk) begin
        if (rst)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
    import alarm_pkg::*;
#(
    parameter int FIELD_W = alarm_pkg::FW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               upd_done_i,
    input  logic               alm_en_i,
    input  logic               flag_rd_i,
    input  logic [FIELD_W-1:0] cur_sec_i,
    input  logic [FIELD_W-1:0] cur_min_i,
    input  logic [FIELD_W-1:0] cur_hr_i,
    input  logic [FIELD_W-1:0] alm_sec_i,
    input  logic [FIELD_W-1:0] alm_min_i,
    input  logic [FIELD_W-1:0] alm_hr_i,
    output logic               alm_flag_o,
    output logic               alm_irq_o
);
    tod_t          now_t;
    tod_t          tgt_t;
    logic [NF-1:0] hit;
    logic          all_hit;
    logic          set_ev;

    always_comb begin
        now_t = '{hr: cur_hr_i, min: cur_min_i, sec: cur_sec_i};
        tgt_t = '{hr: alm_hr_i, min: alm_min_i, sec: alm_sec_i};
    end

    for (genvar g = 0; g < NF; g++) begin : g_field
        alarm_field_cmp u_cmp (
            .cur_i (pick(now_t, g)),
            .alm_i (pick(tgt_t, g)),
            .hit_o (hit[g])
        );
    end

    always_comb begin
        all_hit = &hit;
        set_ev  = upd_done_i & all_hit;
    end

    alarm_flag_reg u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_ev),
        .clr_i  (flag_rd_i),
        .flag_o (alm_flag_o)
    );

    assign alm_irq_o = alm_flag_o & alm_en_i;
endmodule

// File: rtl/alarm_match_chk.sv
module alarm_match_chk
    import alarm_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   upd_done_i,
    input logic   alm_en_i,
    input logic   flag_rd_i,
    input fbyte_t cur_sec_i,
    input fbyte_t cur_min_i,
    input fbyte_t cur_hr_i,
    input fbyte_t alm_sec_i,
    input fbyte_t alm_min_i,
    input fbyte_t alm_hr_i,
    input logic   alm_flag_o,
    input logic   alm_irq_o
);
    logic m_sec, m_min, m_hr, m_all;
    always_comb begin
        m_sec = (alm_sec_i >= 8'hC0) || (alm_sec_i == cur_sec_i);
        m_min = (alm_min_i >= 8'hC0) || (alm_min_i == cur_min_i);
        m_hr  = (alm_hr_i  >= 8'hC0) || (alm_hr_i  == cur_hr_i);
        m_all = m_sec && m_min && m_hr;
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> !alm_flag_o && !alm_irq_o);

    a_r2_set_on_match: assert property (@(posedge clk) disable iff (rst)
        upd_done_i && m_all |=> alm_flag_o);

    a_r3_no_set_without_update: assert property (@(posedge clk) disable iff (rst)
        !alm_flag_o && !upd_done_i |=> !alm_flag_o);

    a_r5_no_set_on_miss: assert property (@(posedge clk) disable iff (rst)
        !alm_flag_o && !m_all |=> !alm_flag_o);

    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        alm_flag_o && !flag_rd_i |=> alm_flag_o);

    a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
        flag_rd_i && !(upd_done_i && m_all) |=> !alm_flag_o);

    a_r8_irq_off: assert property (@(posedge clk) disable iff (rst)
        !alm_en_i |-> !alm_irq_o);

    a_r8_irq_on: assert property (@(posedge clk) disable iff (rst)
        alm_flag_o && alm_en_i |-> alm_irq_o);
endmodule

bind alarm_match_unit alarm_match_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .upd_done_i (upd_done_i),
    .alm_en_i   (alm_en_i),
    .flag_rd_i  (flag_rd_i),
    .cur_sec_i  (cur_sec_i),
    .cur_min_i  (cur_min_i),
    .cur_hr_i   (cur_hr_i),
    .alm_sec_i  (alm_sec_i),
    .alm_min_i  (alm_min_i),
    .alm_hr_i   (alm_hr_i),
    .alm_flag_o (alm_flag_o),
    .alm_irq_o  (alm_irq_o)
);

// File: tb/test_alarm_match_unit.sv
`timescale 1ns/1ps
module test_alarm_match_unit;
    logic       clk = 1'b0;
    logic       rst;
    logic       upd, en, rd;
    logic [7:0] cs, cm, ch, as_, am, ah;
    logic       flag, irq;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    alarm_match_unit i_alarm_match_unit (
        .clk(clk), .rst(rst), .upd_done_i(upd), .alm_en_i(en), .flag_rd_i(rd),
        .cur_sec_i(cs), .cur_min_i(cm), .cur_hr_i(ch),
        .alm_sec_i(as_), .alm_min_i(am), .alm_hr_i(ah),
        .alm_flag_o(flag), .alm_irq_o(irq)
    );

    function automatic logic fmatch(input logic [7:0] c, input logic [7:0] a);
        return (a[7] && a[6]) || (a == c);
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0b expected %0b (cur %h:%h:%h alarm %h:%h:%h en %0b)",
                     req, act, exp, ch, cm, cs, ah, am, as_, en);
        end
    endtask

    task automatic pulse_upd();
        @(negedge clk) upd = 1'b1;
        @(negedge clk) upd = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk) rd = 1'b1;
        @(negedge clk) rd = 1'b0;
    endtask

    initial begin
        rst = 1'b1; upd = 1'b0; en = 1'b0; rd = 1'b0;
        cs = 8'h00; cm = 8'h00; ch = 8'h00;
        as_ = 8'h00; am = 8'h00; ah = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: fields already match, no strobe yet
        chk("R1 reset flag", flag, 1'b0);
        chk("R1 reset irq", irq, 1'b0);

        // R4 R9 R8: per-field sweep of every alarm byte against four current values
        for (int f = 0; f < 3; f++) begin
            for (int a = 0; a < 256; a++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [7:0] c;
                    logic       e;
                    c = (k == 0) ? 8'(a) : (k == 1) ? 8'(a ^ 1) :
                        (k == 2) ? 8'(a ^ 8'h80) : 8'(a ^ 8'h40);
                    cs = 8'h12; cm = 8'h34; ch = 8'h05;
                    as_ = 8'h12; am = 8'h34; ah = 8'h05;
                    case (f)
                        0: begin cs = c; as_ = 8'(a); end
                        1: begin cm = c; am = 8'(a); end
                        default: begin ch = c; ah = 8'(a); end
                    endcase
                    en = a[0];
                    e = fmatch(c, 8'(a));
                    pulse_upd();
                    chk("R4/R9 field sweep flag", flag, e);
                    chk("R8 irq gate", irq, e & en);
                    clear_flag();
                    chk("R6 cleared after read", flag, 1'b0);
                end
            end
        end

        // R2 R5: all wildcard masks over eight time points (daily..per-second)
        en = 1'b1;
        for (int m = 0; m < 8; m++) begin
            for (int p = 0; p < 8; p++) begin
                logic e;
                as_ = m[0] ? 8'hC0 : 8'h2A;
                am  = m[1] ? 8'hE7 : 8'h07;
                ah  = m[2] ? 8'hFF : 8'h85;
                cs  = p[0] ? 8'h2A : 8'h00;
                cm  = p[1] ? 8'h07 : 8'h00;
                ch  = p[2] ? 8'h85 : 8'h05;
                e = fmatch(cs, as_) && fmatch(cm, am) && fmatch(ch, ah);
                pulse_upd();
                if (m == 0 && p == 7) chk("R2 daily exact match", flag, 1'b1);
                else if (e) chk("R2 wildcard mask match", flag, 1'b1);
                else chk("R5 mismatch no set", flag, 1'b0);
                clear_flag();
            end
        end

        // R3: match held with no strobe
        cs = 8'h10; cm = 8'h20; ch = 8'h11;
        as_ = 8'h10; am = 8'h20; ah = 8'h11;
        repeat (10) @(negedge clk);
        chk("R3 no strobe no set", flag, 1'b0);

        // R6: sticky across cycles, then changed time does not clear it
        pulse_upd();
        cs = 8'h11;
        repeat (5) @(negedge clk);
        chk("R6 sticky", flag, 1'b1);

        // R7: read and new match on the same edge
        cs = 8'h10;
        @(negedge clk) begin rd = 1'b1; upd = 1'b1; end
        @(negedge clk) begin rd = 1'b0; upd = 1'b0; end
        chk("R7 read vs match keeps flag", flag, 1'b1);

        // R6: read together with a non-matching update clears
        cs = 8'h11;
        @(negedge clk) begin rd = 1'b1; upd = 1'b1; end
        @(negedge clk) begin rd = 1'b0; upd = 1'b0; end
        chk("R6 read with miss clears", flag, 1'b0);

        // R8: flag set while disabled, irq appears when enabled
        en = 1'b0; cs = 8'h10;
        pulse_upd();
        chk("R8 flag set while disabled", flag, 1'b1);
        chk("R8 irq low while disabled", irq, 1'b0);
        @(negedge clk) en = 1'b1;
        #1 chk("R8 irq follows enable", irq, 1'b1);

        // R1: reset mid-run clears
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        chk("R1 reset clears flag", flag, 1'b0);
        chk("R1 reset clears irq", irq, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule